// File: doc/BRIEF.md
# Banked Low-Power Synchronous RAM

This block is a single-port synchronous memory of 2048 eight-bit words. The storage is split into four banks of 512 words, and each bank has its own enable. The upper two address bits pick the bank and the lower nine bits pick the word inside it. A bank is switched on only in a cycle where an access to it is requested, so at most one of the four banks draws active power in any cycle. In idle cycles none of them does.

Writes are stored at the rising clock edge. A read returns its data just after the edge that samples its address. The bank index is registered together with the read, so the output multiplexer always selects the bank that was read. The read output follows a no-change policy: a write cycle or an idle cycle leaves it at its last read value. The per-bank enable vector is a port, so the enable behaviour can be observed.

Top module: `banked_sram`

## Requirements
- R1: The memory holds 2048 independent 8-bit words. Each address written and then read back returns its own data.
- R2: When `req` is high, `bank_en` bit k is set, where k = `addr[10:9]`. Bank 0 covers addresses 0x000-0x1FF and bank 3 covers 0x600-0x7FF.
- R3: `bank_en` has at most one bit set in any cycle.
- R4: When `req` is low, `bank_en` is all zero, whatever `wr` and `addr` are.
- R5: With `req`=1 and `wr`=1, `wdata` is stored at `addr` at the rising clock edge.
- R6: With `req`=1 and `wr`=0, `rdata` shows the word at `addr` right after the rising edge that samples the request. This is one cycle of latency.
- R7: In a write cycle, `rdata` keeps the value it had before the cycle. It does not show the written data.
- R8: In a cycle with `req`=0, `rdata` keeps its value. A `wr`=1 in such a cycle changes no stored word.
- R9: While `rst_n` is low, `rdata` is 0.
- R10: Words in different banks that share the same 9-bit in-bank offset are distinct storage locations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the read path |
| req | input | 1 | Access request for this cycle |
| wr | input | 1 | 1 = write, 0 = read (meaningful only with req) |
| addr | input | 11 | Word address; [10:9] bank, [8:0] offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, held between reads |
| bank_en | output | 4 | Per-bank enable, one-hot or zero |

## Verification
The case that is hardest to reach from the ports is a read-output multiplexer that selects the wrong bank. It stays hidden when the previously read bank happens to hold the same value at that offset. The bench therefore fills all 2048 words with a pattern that depends on the bank index as well as the offset, then reads them back one after another so that every bank boundary is crossed. The vector table places writes and idle cycles with `wr` high directly after reads of distinct values. This way a held output can be told apart from a freshly read or freshly written one.

// File: rtl/banked_sram.sv
module banked_sram #(
  parameter int DATA_W  = 8,
  parameter int WORD_AW = 9,
  parameter int BANK_AW = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              req,
  input  logic                              wr,
  input  logic [WORD_AW+BANK_AW-1:0]        addr,
  input  logic [DATA_W-1:0]                 wdata,
  output logic [DATA_W-1:0]                 rdata,
  output logic [(1<<BANK_AW)-1:0]           bank_en
);
  localparam int NBANKS = 1 << BANK_AW;
  localparam int ADDR_W = WORD_AW + BANK_AW;
  localparam int DEPTH  = 1 << WORD_AW;

  logic [BANK_AW-1:0] bank_id;
  logic [WORD_AW-1:0] word;
  logic               rd;
  logic [BANK_AW-1:0] sel_q;
  logic [NBANKS-1:0][DATA_W-1:0] bank_rd;

  assign bank_id = addr[ADDR_W-1:WORD_AW];
  assign word    = addr[WORD_AW-1:0];
  assign rd      = req & ~wr;
  assign bank_en = req ? (NBANKS'(1) << bank_id) : '0;

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] q;

    always_ff @(posedge clk)
      if (bank_en[b] && wr) mem[word] <= wdata;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                 q <= '0;
      else if (bank_en[b] && !wr) q <= mem[word];

    assign bank_rd[b] = q;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)  sel_q <= '0;
    else if (rd) sel_q <= bank_id;

  assign rdata = bank_rd[sel_q];

  a_r3_onehot_en: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_en));
  a_r4_idle_no_en: assert property (@(posedge clk) disable iff (!rst_n)
    !req |-> (bank_en == '0));
  a_r2_addressed_bank: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> bank_en[bank_id]);
  a_r7_write_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (req && wr) |=> $stable(rdata));
  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> $stable(rdata));
endmodule

// File: tb/sim_banked_sram.sv
`timescale 1ns/1ps
module sim_banked_sram;
  logic clk = 0, rst_n = 0, req = 0, wr = 0;
  logic [10:0] addr = '0;
  logic [7:0]  wdata = '0, rdata;
  logic [3:0]  bank_en;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  banked_sram u0 (.clk, .rst_n, .req, .wr, .addr, .wdata, .rdata, .bank_en);

  // {req, wr, addr, wdata, expected rdata after edge, expected bank_en}
  localparam int NV = 15;
  localparam logic [32:0] VEC [NV] = '{
    {1'b1,1'b1,11'h000,8'hA1,8'h00,4'b0001},
    {1'b1,1'b1,11'h200,8'hB2,8'h00,4'b0010},
    {1'b1,1'b1,11'h400,8'hC3,8'h00,4'b0100},
    {1'b1,1'b1,11'h7FF,8'hD4,8'h00,4'b1000},
    {1'b1,1'b0,11'h000,8'h00,8'hA1,4'b0001},
    {1'b1,1'b1,11'h1FF,8'h5E,8'hA1,4'b0001},
    {1'b0,1'b0,11'h200,8'h00,8'hA1,4'b0000},
    {1'b1,1'b0,11'h200,8'h00,8'hB2,4'b0010},
    {1'b1,1'b0,11'h400,8'h00,8'hC3,4'b0100},
    {1'b1,1'b0,11'h7FF,8'h00,8'hD4,4'b1000},
    {1'b1,1'b0,11'h1FF,8'h00,8'h5E,4'b0001},
    {1'b1,1'b1,11'h600,8'h77,8'h5E,4'b1000},
    {1'b1,1'b0,11'h600,8'h00,8'h77,4'b1000},
    {1'b0,1'b1,11'h000,8'hFF,8'h77,4'b0000},
    {1'b1,1'b0,11'h000,8'h00,8'hA1,4'b0001}
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(logic [10:0] a);
    return a[7:0] ^ (8'h47 * a[10:9]) ^ {7'd0, a[8]};
  endfunction

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset rdata", rdata, 0);
    check("R4 reset idle bank_en", bank_en, 0);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {req, wr, addr, wdata} = VEC[i][32:12];
      #1 check($sformatf("R2/R3/R4 vec%0d bank_en", i), bank_en, VEC[i][3:0]);
      @(posedge clk); #1;
      // R5 R6 R7 R8 covered by vector expectations
      check($sformatf("R5-R8 vec%0d rdata", i), rdata, VEC[i][11:4]);
    end

    // R1 / R10: fill whole memory with bank-dependent pattern
    for (int a = 0; a < 2048; a++) begin
      @(negedge clk);
      req = 1; wr = 1; addr = 11'(a); wdata = pat(11'(a));
    end
    for (int a = 0; a < 2048; a++) begin
      @(negedge clk);
      req = 1; wr = 0; addr = 11'(a);
      #1 if ($countones(bank_en) != 1 || !bank_en[a>>9])
        check("R3 fill bank_en", bank_en, 32'(1 << (a >> 9)));
      @(posedge clk); #1;
      if ((a % 97) == 0 || (a % 512) == 0 || (a % 512) == 511)
        check("R1 R10 readback", rdata, pat(11'(a)));
      else if (rdata !== pat(11'(a)))
        check("R1 R10 readback", rdata, pat(11'(a)));
    end

    // R10 offset 5 in every bank distinct
    for (int b = 0; b < 4; b++) begin
      @(negedge clk);
      req = 1; wr = 0; addr = {2'(b), 9'd5};
      @(posedge clk); #1;
      check("R10 same offset other bank", rdata, pat({2'(b), 9'd5}));
    end

    // R9 reset mid-run clears read output
    @(negedge clk);
    req = 0; rst_n = 0;
    #1 check("R9 mid-run reset rdata", rdata, 0);
    @(negedge clk);
    rst_n = 1;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule